// File: doc/BRIEF.md
# Actuator Driver Mode Sequencer

This controller selects the operating mode of a head-actuator power stage: park, high-impedance (tristate) or run. It takes an already digitised logic-supply-good flag, an active-low enable from the drive controller and an active-low park request. From these it produces an active-low power-on-reset, an active-low write-disable and three one-hot mode strobes for the power stage.

After reset, or after any supply loss, the block holds power-on-reset and write-disable low and keeps the stage parked. It releases both only once the supply has stayed good for a programmed number of cycles. When the supply fails, write-disable drops first, so that read/write activity can stop. Power-on-reset follows a programmed number of cycles later, and that edge forces the stage into park. While power-on-reset is low, enable is ignored. A park request overrides enable in every state.

All three inputs pass through two-flop synchronizers before any logic uses them. The hold-off length and the write-disable lead are parameters counted in clock cycles.

Top module: `actuator_mode_seq`

## Requirements
- R1: While `rstN` is low, `porN`=0, `wrDisN`=0 and `modePark`=1, with `modeTri`=0 and `modeRun`=0.
- R2: `porN` and `wrDisN` rise in the same cycle. This happens DELAY_CYCLES cycles after the synchronized supply flag has been continuously high. With the two synchronizer stages, that is DELAY_CYCLES+2 clock edges after a raw rise of `supplyOk`. A supply dropout during the hold-off restarts the count.
- R3: One cycle after `porN` rises, the mode becomes run if `enableN` is low and tristate if it is high.
- R4: While `porN` is high and no park is requested, the mode follows enable: a low `enableN` selects run and a high `enableN` selects tristate. The mode changes on the clock edge after the synchronized value changes.
- R5: On a supply failure with `porN` high, `wrDisN` falls first. `porN` falls exactly LEAD_CYCLES cycles later.
- R6: In the cycle after `porN` is seen low, the mode is park. No other mode appears in between.
- R7: A low synchronized `parkReqN` gives park mode on the next edge, in any state. When the request is released, the mode chosen by enable returns.
- R8: While `porN` is low, the mode stays park whatever the value of `enableN`.
- R9: If the supply returns during the write-disable lead, `wrDisN` stays low and `porN` still falls. `porN` then stays low for a full DELAY_CYCLES cycles.
- R10: In every cycle exactly one of `modePark`, `modeTri` and `modeRun` is 1.
- R11: Each input reaches the mode and reset logic through two flop stages. A change on `enableN` alters the mode only on the third clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Digitised logic-supply-good flag, asynchronous |
| enableN | input | 1 | Active-low enable from controller, asynchronous |
| parkReqN | input | 1 | Active-low park request, asynchronous |
| porN | output | 1 | Active-low power-on-reset |
| wrDisN | output | 1 | Active-low write-disable |
| modePark | output | 1 | Power stage in park mode |
| modeTri | output | 1 | Power stage outputs high-impedance |
| modeRun | output | 1 | Power stage in linear run mode |

## Verification
The supply flag is driven with a clean rise, with a short dropout inside the hold-off, with a failure from run, and with a failure that recovers inside the write-disable lead. These patterns separate a count that restarts from one that only pauses, and a correct lead length from one that is off by one. They also separate a lead that can be cut short from one that always completes. Enable is toggled while reset is held, to show that it is ignored, and then in tristate and run, to check the transitions and the synchronizer latency. Park requests are pulsed in both tristate and run to show that park takes priority and that the mode returns after release.

// File: rtl/act_seq_pkg.sv
package act_seq_pkg;

  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_UP   = 2'd1,
    PH_LEAD = 2'd2
  } supplyPhase_t;

  typedef enum logic [2:0] {
    MODE_PARK = 3'b001,
    MODE_TRI  = 3'b010,
    MODE_RUN  = 3'b100
  } mode_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } cntStrobe_t;

endpackage

// File: rtl/act_seq_sync.sv
module act_seq_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RESET_VAL}};
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/act_seq_datapath.sv
module act_seq_datapath
  import act_seq_pkg::*;
#(
  parameter int DELAY_CYCLES = 1000,
  parameter int LEAD_CYCLES  = 200,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       enableN,
  input  logic       parkReqN,
  input  cntStrobe_t strobe,
  output logic       sOk,
  output logic       sEnN,
  output logic       sParkN,
  output logic       delayDone,
  output logic       leadDone
);
  localparam int MAXC = (DELAY_CYCLES > LEAD_CYCLES) ? DELAY_CYCLES : LEAD_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_VALS = 3'b110;

  logic [NSIG-1:0] rawIn;
  logic [NSIG-1:0] syncOut;
  logic [CW-1:0]   cnt;

  assign rawIn = {parkReqN, enableN, supplyOk};

  for (genvar i = 0; i < NSIG; i++) begin : g_sync
    act_seq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(RST_VALS[i])) u_sync (
      .clk (clk),
      .rstN(rstN),
      .d   (rawIn[i]),
      .q   (syncOut[i])
    );
  end

  assign sOk    = syncOut[0];
  assign sEnN   = syncOut[1];
  assign sParkN = syncOut[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.cntClear) cnt <= '0;
    else if (strobe.cntInc)   cnt <= cnt + 1'b1;
  end

  assign delayDone = (cnt == CW'(DELAY_CYCLES - 1));
  assign leadDone  = (cnt == CW'(LEAD_CYCLES - 1));

  // R2: shared counter never runs past the longer window
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    int'(cnt) < MAXC);

  // R2: control never asks to clear and advance at once
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cntClear && strobe.cntInc));
endmodule

// File: rtl/act_seq_control.sv
module act_seq_control
  import act_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sOk,
  input  logic       sEnN,
  input  logic       sParkN,
  input  logic       delayDone,
  input  logic       leadDone,
  output cntStrobe_t strobe,
  output logic       porN,
  output logic       wrDisN,
  output mode_t      mode
);
  supplyPhase_t phase, phaseNext;
  mode_t        modeNext;

  always_comb begin
    phaseNext       = phase;
    strobe.cntClear = 1'b0;
    strobe.cntInc   = 1'b0;
    case (phase)
      PH_HOLD: begin
        if (!sOk) begin
          strobe.cntClear = 1'b1;
        end else if (delayDone) begin
          strobe.cntClear = 1'b1;
          phaseNext       = PH_UP;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      PH_UP: begin
        strobe.cntClear = 1'b1;
        if (!sOk) phaseNext = PH_LEAD;
      end
      PH_LEAD: begin
        if (leadDone) begin
          strobe.cntClear = 1'b1;
          phaseNext       = PH_HOLD;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: begin
        strobe.cntClear = 1'b1;
        phaseNext       = PH_HOLD;
      end
    endcase
  end

  always_comb begin
    if (phase == PH_HOLD || !sParkN) modeNext = MODE_PARK;
    else if (!sEnN)                  modeNext = MODE_RUN;
    else                             modeNext = MODE_TRI;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_HOLD;
      mode  <= MODE_PARK;
    end else begin
      phase <= phaseNext;
      mode  <= modeNext;
    end
  end

  assign porN   = (phase != PH_HOLD);
  assign wrDisN = (phase == PH_UP);

  // R10: exactly one mode strobe
  p_mode_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(mode) == 1);

  // R6: reset low leads to park on the next edge
  p_por_parks_r6: assert property (@(posedge clk) disable iff (!rstN)
    !porN |=> (mode == MODE_PARK));

  // R7: park request wins over everything
  p_park_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    !sParkN |=> (mode == MODE_PARK));

  // R5: write-disable already low before reset falls
  p_wr_leads_por_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(porN) |-> (!wrDisN && $past(!wrDisN)));

  // R2: both outputs release together
  p_rise_together_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(porN) |-> $rose(wrDisN));

  // R9: once write-disable drops with reset high, it stays low
  p_lead_no_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!wrDisN && porN) |=> !wrDisN);

  // R8: enable cannot leave park while reset is held
  p_enable_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!porN && $past(!porN)) |-> (mode == MODE_PARK));
endmodule

// File: rtl/actuator_mode_seq.sv
module actuator_mode_seq
  import act_seq_pkg::*;
#(
  parameter int DELAY_CYCLES = 1000,
  parameter int LEAD_CYCLES  = 200,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic enableN,
  input  logic parkReqN,
  output logic porN,
  output logic wrDisN,
  output logic modePark,
  output logic modeTri,
  output logic modeRun
);
  cntStrobe_t strobe;
  logic       sOk, sEnN, sParkN, delayDone, leadDone;
  mode_t      mode;

  act_seq_datapath #(
    .DELAY_CYCLES(DELAY_CYCLES),
    .LEAD_CYCLES (LEAD_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .supplyOk (supplyOk),
    .enableN  (enableN),
    .parkReqN (parkReqN),
    .strobe   (strobe),
    .sOk      (sOk),
    .sEnN     (sEnN),
    .sParkN   (sParkN),
    .delayDone(delayDone),
    .leadDone (leadDone)
  );

  act_seq_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .sOk      (sOk),
    .sEnN     (sEnN),
    .sParkN   (sParkN),
    .delayDone(delayDone),
    .leadDone (leadDone),
    .strobe   (strobe),
    .porN     (porN),
    .wrDisN   (wrDisN),
    .mode     (mode)
  );

  assign modePark = mode[0];
  assign modeTri  = mode[1];
  assign modeRun  = mode[2];
endmodule

// File: tb/actuator_mode_seq_bench.sv
module actuator_mode_seq_bench;
  localparam int DELAY = 20;
  localparam int LEAD  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0;
  logic enableN = 1'b1;
  logic parkReqN = 1'b1;
  logic porN, wrDisN, modePark, modeTri, modeRun;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  actuator_mode_seq #(.DELAY_CYCLES(DELAY), .LEAD_CYCLES(LEAD)) u_actuator_mode_seq (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .enableN(enableN), .parkReqN(parkReqN),
    .porN(porN), .wrDisN(wrDisN), .modePark(modePark), .modeTri(modeTri), .modeRun(modeRun)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // behavioural reference: phase 0 held, 1 released, 2 write-disable lead
  // mode 0 park, 1 tristate, 2 run
  int mOk1, mOk2, mEn1, mEn2, mPk1, mPk2, mPhase, mCnt, mMode;

  always @(posedge clk) begin
    int nMode;
    if (!rstN) begin
      mOk1 = 0; mOk2 = 0; mEn1 = 1; mEn2 = 1; mPk1 = 1; mPk2 = 1;
      mPhase = 0; mCnt = 0; mMode = 0;
    end else begin
      if (mPhase == 0 || mPk2 == 0) nMode = 0;
      else if (mEn2 == 0)           nMode = 2;
      else                          nMode = 1;
      if (mPhase == 0) begin
        if (mOk2 == 0) mCnt = 0;
        else if (mCnt == DELAY - 1) begin mPhase = 1; mCnt = 0; end
        else mCnt++;
      end else if (mPhase == 1) begin
        if (mOk2 == 0) begin mPhase = 2; mCnt = 0; end
      end else begin
        if (mCnt == LEAD - 1) begin mPhase = 0; mCnt = 0; end
        else mCnt++;
      end
      mMode = nMode;
      mOk2 = mOk1; mOk1 = int'(supplyOk);
      mEn2 = mEn1; mEn1 = int'(enableN);
      mPk2 = mPk1; mPk1 = int'(parkReqN);
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R5", int'(porN), int'(mPhase != 0));
      check("R2", int'(wrDisN), int'(mPhase == 1));
      check("R7", int'({modeRun, modeTri, modePark}), 1 << mMode);
      check("R10", int'(modeRun) + int'(modeTri) + int'(modePark), 1);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int n;
    cyc(3);
    check("R1", int'(porN), 0);
    check("R1", int'(wrDisN), 0);
    check("R1", int'({modeRun, modeTri, modePark}), 1);
    rstN = 1'b1;
    cyc(5);
    // first power-up with a dropout inside the hold-off
    supplyOk = 1'b1;
    cyc(8);
    supplyOk = 1'b0;
    cyc(2);
    enableN = 1'b0;
    supplyOk = 1'b1;
    n = 0;
    cyc(4);
    n += 4;
    check("R8", int'(modePark), 1);
    enableN = 1'b1;
    while (!porN && n < 200) begin cyc(1); n++; end
    check("R2", n, DELAY + 2);
    check("R2", int'(wrDisN), 1);
    cyc(1);
    check("R3", int'(modeTri), 1);
    // enable latency and transitions
    enableN = 1'b0;
    cyc(2);
    check("R11", int'(modeTri), 1);
    cyc(1);
    check("R4", int'(modeRun), 1);
    parkReqN = 1'b0;
    cyc(3);
    check("R7", int'(modePark), 1);
    parkReqN = 1'b1;
    cyc(3);
    check("R7", int'(modeRun), 1);
    enableN = 1'b1;
    cyc(3);
    check("R4", int'(modeTri), 1);
    parkReqN = 1'b0;
    cyc(3);
    check("R7", int'(modePark), 1);
    parkReqN = 1'b1;
    enableN = 1'b0;
    cyc(3);
    check("R4", int'(modeRun), 1);
    // supply failure from run
    supplyOk = 1'b0;
    n = 0;
    while (wrDisN && n < 50) begin cyc(1); n++; end
    check("R5", int'(porN), 1);
    n = 0;
    while (porN && n < 50) begin cyc(1); n++; end
    check("R5", n, LEAD);
    check("R6", int'(modeRun), 1);
    cyc(1);
    check("R6", int'(modePark), 1);
    // second power-up with enable asserted
    supplyOk = 1'b1;
    n = 0;
    while (!porN && n < 200) begin cyc(1); n++; end
    check("R2", n, DELAY + 2);
    cyc(1);
    check("R3", int'(modeRun), 1);
    // failure that recovers inside the lead
    supplyOk = 1'b0;
    n = 0;
    while (wrDisN && n < 50) begin cyc(1); n++; end
    cyc(1);
    supplyOk = 1'b1;
    n = 0;
    while (porN && n < 50) begin
      check("R9", int'(wrDisN), 0);
      cyc(1);
      n++;
    end
    check("R9", int'(porN), 0);
    enableN = 1'b1;
    n = 0;
    while (!porN && n < 200) begin cyc(1); n++; end
    check("R9", n, DELAY);
    cyc(1);
    check("R3", int'(modeTri), 1);
    cyc(5);
    finishRun();
  end
endmodule